// File: doc/BRIEF.md
# Test Pattern Buffer Address Controller

This block drives the address side of an external 256K x 16 sample memory that serves two kinds of audio content: a set of looping test-tone tables and a stereo auxiliary stream held in ping-pong buffers. Each audio sample tick starts one fetch of one channel sample, which is two 16-bit words read on two consecutive cycles (even word first, odd word second). Ticks alternate between the left and the right channel. The source of each fetch, test tone or auxiliary, is chosen per tick, as is the tone table.

The auxiliary stream has four regions: left and right for half A, and left and right for half B. Playback reads the active half. When its last sample has been read, the halves swap. The controller then raises a refill request so the processor can fill the idle half. If that request is still pending at the next swap, a sticky underrun bit is set and playback goes on without a stall.

The processor writes to the memory through the same controller. A write is held until a cycle in which no audio fetch uses the memory.

Top module: `tpb_addr_ctrl`

## Requirements
- R1: After reset there is no memory read or write, `irq_o`, `underrun_o`, `cpu_busy_o` and `aux_half_o` are all 0, the channel is left, and both sample pointers are 0.
- R2: A tick sampled with the fetcher idle reads the memory for exactly two cycles, starting the cycle after the tick. The first word is at an even address and the second at that address plus one.
- R3: The first fetch after reset is for the left channel, and channels alternate after that. A test-tone fetch reads word address `sel*2*TONE_SAMPLES + 2*idx` (plus 1 for the second word). Both channels of a sample use the same index. The index advances after the right-channel fetch and wraps from TONE_SAMPLES-1 to 0.
- R4: An auxiliary fetch reads word address `AUX_BASE + (2*half + chan)*2*AUX_SAMPLES + 2*idx`, where chan is 0 for left and 1 for right, half is 0 for A and 1 for B, and `AUX_BASE = NUM_TONES*2*TONE_SAMPLES`. The auxiliary index advances after the right-channel fetch.
- R5: When the right-channel fetch of the last auxiliary sample completes, `aux_half_o` toggles, the auxiliary index returns to 0, and `irq_o` goes to 1 on the following cycle.
- R6: A `cpu_ack_i` pulse clears `irq_o` and `underrun_o` on the following cycle. A swap on the same cycle takes precedence and sets `irq_o`.
- R7: A swap while `irq_o` is still 1 sets `underrun_o`. Fetches carry on with the same timing and addressing.
- R8: A `cpu_wr_i` pulse captures `cpu_addr_i` and `cpu_wdata_i` and raises `cpu_busy_o` on the next cycle. The write drives `mem_wr_o` in the first cycle with no fetch. `cpu_busy_o` falls after that cycle.
- R9: `mem_rd_o` and `mem_wr_o` are never 1 in the same cycle.
- R10: The source and tone selection are captured with the tick. Changing them during a fetch has no effect on that fetch. Each source keeps its own pointer across source changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle sample tick that starts a fetch |
| src_aux_i | input | 1 | 1 selects the auxiliary stream, 0 selects a test tone |
| tone_sel_i | input | TSEL_W (2) | Tone table number |
| cpu_wr_i | input | 1 | One-cycle processor write request |
| cpu_addr_i | input | ADDR_W (18) | Processor write word address |
| cpu_wdata_i | input | DATA_W (16) | Processor write data |
| cpu_ack_i | input | 1 | Refill acknowledge pulse |
| mem_addr_o | output | ADDR_W (18) | Memory word address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DATA_W (16) | Memory write data |
| cpu_busy_o | output | 1 | A processor write is pending |
| irq_o | output | 1 | Refill request for the idle auxiliary half |
| underrun_o | output | 1 | Sticky flag: a swap found the previous refill unacknowledged |
| aux_half_o | output | 1 | Active auxiliary half (0 = A, 1 = B) |

## Verification
The assertions rely on two conditions at the inputs. First, a tick arrives only while the fetcher is idle, so ticks are at least three cycles apart. Second, `cpu_wr_i` is pulsed only while `cpu_busy_o` is 0.

The stimulus meets both conditions. It waits several cycles after every tick and waits for each write to drain before it issues the next one. The one write that overlaps a fetch is issued on the same cycle as the tick, so the hold path is exercised without breaking either condition.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_WORD0 = 2'd1,
      FS_WORD1 = 2'd2
   } fetch_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tpb_fetch_seq.sv
module tpb_fetch_seq
   import tpb_pkg::*;
#(
   parameter int TSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              src_aux_i,
   input  logic [TSEL_W-1:0] tone_sel_i,
   output logic              busy_o,
   output logic              word_o,
   output logic              done_o,
   output logic              chan_o,
   output logic              src_o,
   output logic [TSEL_W-1:0] sel_o
);
   fetch_state_e      state_q;
   logic              chan_q;
   logic              src_q;
   logic [TSEL_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         chan_q  <= 1'b0;
         src_q   <= 1'b0;
         sel_q   <= '0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (tick_i) begin
                  state_q <= FS_WORD0;
                  src_q   <= src_aux_i;
                  sel_q   <= tone_sel_i;
               end
            end
            FS_WORD0: state_q <= FS_WORD1;
            FS_WORD1: begin
               state_q <= FS_IDLE;
               chan_q  <= ~chan_q;
            end
            default:  state_q <= FS_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != FS_IDLE);
   assign word_o = (state_q == FS_WORD1);
   assign done_o = (state_q == FS_WORD1);
   assign chan_o = chan_q;
   assign src_o  = src_q;
   assign sel_o  = sel_q;

   // input assumption: ticks only reach an idle fetcher
   AST_TICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |-> (state_q == FS_IDLE)); // R2

   AST_CHAN_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (chan_q != $past(chan_q))); // R3

   AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_WORD0) |=> ($stable(src_q) && $stable(sel_q))); // R10
endmodule

// File: rtl/tpb_ptr_ctrl.sv
module tpb_ptr_ctrl #(
   parameter int TONE_SAMPLES = 8192,
   parameter int AUX_SAMPLES  = 24576,
   localparam int TONE_IW     = $clog2(TONE_SAMPLES),
   localparam int AUX_IW      = $clog2(AUX_SAMPLES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done_i,
   input  logic               chan_i,
   input  logic               src_aux_i,
   input  logic               ack_i,
   output logic [TONE_IW-1:0] tone_idx_o,
   output logic [AUX_IW-1:0]  aux_idx_o,
   output logic               half_o,
   output logic               irq_o,
   output logic               underrun_o
);
   localparam logic [TONE_IW-1:0] TONE_LAST = TONE_IW'(TONE_SAMPLES - 1);
   localparam logic [AUX_IW-1:0]  AUX_LAST  = AUX_IW'(AUX_SAMPLES - 1);

   logic [TONE_IW-1:0] tone_idx_q;
   logic [AUX_IW-1:0]  aux_idx_q;
   logic               half_q, irq_q, und_q;
   logic               step_w, swap_w;

   assign step_w = done_i && chan_i;
   assign swap_w = step_w && src_aux_i && (aux_idx_q == AUX_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tone_idx_q <= '0;
      end else if (step_w && !src_aux_i) begin
         tone_idx_q <= (tone_idx_q == TONE_LAST) ? '0 : tone_idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aux_idx_q <= '0;
         half_q    <= 1'b0;
      end else if (step_w && src_aux_i) begin
         aux_idx_q <= swap_w ? '0 : aux_idx_q + 1'b1;
         if (swap_w) half_q <= ~half_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         und_q <= 1'b0;
      end else begin
         if (swap_w)     irq_q <= 1'b1;
         else if (ack_i) irq_q <= 1'b0;
         if (swap_w && irq_q) und_q <= 1'b1;
         else if (ack_i)      und_q <= 1'b0;
      end
   end

   assign tone_idx_o = tone_idx_q;
   assign aux_idx_o  = aux_idx_q;
   assign half_o     = half_q;
   assign irq_o      = irq_q;
   assign underrun_o = und_q;

   AST_AUX_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      aux_idx_q <= AUX_LAST); // R4

   AST_SWAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (half_q != $past(half_q)) |-> irq_q); // R5

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !swap_w) |=> (!irq_q && !und_q)); // R6

   AST_UNDERRUN_AT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(und_q) |-> (half_q != $past(half_q))); // R7
endmodule

// File: rtl/tpb_addr_gen.sv
module tpb_addr_gen
   import tpb_pkg::*;
#(
   parameter int ADDR_W       = 18,
   parameter int NUM_TONES    = 4,
   parameter int TONE_SAMPLES = 8192,
   parameter int AUX_SAMPLES  = 24576,
   localparam int TSEL_W      = $clog2(NUM_TONES),
   localparam int TONE_IW     = $clog2(TONE_SAMPLES),
   localparam int AUX_IW      = $clog2(AUX_SAMPLES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy_i,
   input  logic               src_aux_i,
   input  logic [TSEL_W-1:0]  sel_i,
   input  logic               chan_i,
   input  logic               word_i,
   input  logic               half_i,
   input  logic [TONE_IW-1:0] tone_idx_i,
   input  logic [AUX_IW-1:0]  aux_idx_i,
   output logic [ADDR_W-1:0]  rd_addr_o
);
   localparam int TONE_WORDS = 2 * TONE_SAMPLES;
   localparam int AUX_WORDS  = 2 * AUX_SAMPLES;
   localparam int AUX_BASE   = NUM_TONES * TONE_WORDS;
   localparam logic [ADDR_W-1:0] TONE_WORDS_A = ADDR_W'(TONE_WORDS);
   localparam logic [ADDR_W-1:0] AUX_WORDS_A  = ADDR_W'(AUX_WORDS);
   localparam logic [ADDR_W-1:0] AUX_BASE_A   = ADDR_W'(AUX_BASE);

   logic [ADDR_W-1:0] tone_addr, aux_off, aux_addr;
   logic [1:0]        region;

   assign region = {half_i, chan_i};

   generate
      if (is_pow2(TONE_SAMPLES) && is_pow2(NUM_TONES)) begin : g_tone_pack
         assign tone_addr = ADDR_W'({sel_i, tone_idx_i, word_i});
      end else begin : g_tone_mul
         assign tone_addr = ADDR_W'(sel_i) * TONE_WORDS_A
                          + (ADDR_W'(tone_idx_i) << 1) + ADDR_W'(word_i);
      end

      if (is_pow2(AUX_SAMPLES)) begin : g_aux_pack
         assign aux_off = ADDR_W'({region, aux_idx_i, word_i});
      end else begin : g_aux_mul
         assign aux_off = ADDR_W'(region) * AUX_WORDS_A
                        + (ADDR_W'(aux_idx_i) << 1) + ADDR_W'(word_i);
      end
   endgenerate

   assign aux_addr  = AUX_BASE_A + aux_off;
   assign rd_addr_o = src_aux_i ? aux_addr : tone_addr;

   AST_AUX_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && src_aux_i) |-> (rd_addr_o >= AUX_BASE_A)); // R4

   AST_TONE_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !src_aux_i) |-> (rd_addr_o < AUX_BASE_A)); // R3
endmodule

// File: rtl/tpb_wr_arb.sv
module tpb_wr_arb #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_busy_i,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              grant_o,
   output logic              pend_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   logic              pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              grant_w;

   assign grant_w = pend_q && !fetch_busy_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (req_i && !pend_q) begin
         pend_q <= 1'b1;
         addr_q <= addr_i;
         data_q <= data_i;
      end else if (grant_w) begin
         pend_q <= 1'b0;
      end
   end

   assign grant_o = grant_w;
   assign pend_o  = pend_q;
   assign addr_o  = addr_q;
   assign data_o  = data_q;

   AST_WR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !pend_q) |=> pend_q); // R8

   AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && fetch_busy_i) |=> (pend_q && $stable(addr_q) && $stable(data_q))); // R8

   AST_WR_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_w && !req_i) |=> !pend_q); // R8
endmodule

// File: rtl/tpb_addr_ctrl.sv
module tpb_addr_ctrl #(
   parameter int ADDR_W       = 18,
   parameter int DATA_W       = 16,
   parameter int NUM_TONES    = 4,
   parameter int TONE_SAMPLES = 8192,
   parameter int AUX_SAMPLES  = 24576,
   localparam int TSEL_W      = $clog2(NUM_TONES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              src_aux_i,
   input  logic [TSEL_W-1:0] tone_sel_i,
   input  logic              cpu_wr_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   input  logic              cpu_ack_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              cpu_busy_o,
   output logic              irq_o,
   output logic              underrun_o,
   output logic              aux_half_o
);
   localparam int TONE_IW = $clog2(TONE_SAMPLES);
   localparam int AUX_IW  = $clog2(AUX_SAMPLES);
   localparam longint unsigned USED_WORDS =
      longint'(NUM_TONES) * 2 * TONE_SAMPLES + longint'(4) * 2 * AUX_SAMPLES;
   localparam longint unsigned MEM_WORDS = 64'd1 << ADDR_W;

   generate
      if (NUM_TONES < 2)     begin : g_err_tones $error("NUM_TONES must be at least 2"); end
      if (TONE_SAMPLES < 2)  begin : g_err_tone  $error("TONE_SAMPLES must be at least 2"); end
      if (AUX_SAMPLES < 2)   begin : g_err_aux   $error("AUX_SAMPLES must be at least 2"); end
      if (USED_WORDS > MEM_WORDS) begin : g_err_fit $error("regions exceed the address space"); end
      if (DATA_W < 1)        begin : g_err_data  $error("DATA_W must be positive"); end
   endgenerate

   logic               f_busy, f_word, f_done, f_chan, f_src;
   logic [TSEL_W-1:0]  f_sel;
   logic [TONE_IW-1:0] tone_idx;
   logic [AUX_IW-1:0]  aux_idx;
   logic               half;
   logic [ADDR_W-1:0]  rd_addr, wr_addr;
   logic               wr_grant, wr_pend;
   logic [DATA_W-1:0]  wr_data;

   tpb_fetch_seq #(.TSEL_W(TSEL_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .src_aux_i  (src_aux_i),
      .tone_sel_i (tone_sel_i),
      .busy_o     (f_busy),
      .word_o     (f_word),
      .done_o     (f_done),
      .chan_o     (f_chan),
      .src_o      (f_src),
      .sel_o      (f_sel)
   );

   tpb_ptr_ctrl #(.TONE_SAMPLES(TONE_SAMPLES), .AUX_SAMPLES(AUX_SAMPLES)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (f_done),
      .chan_i     (f_chan),
      .src_aux_i  (f_src),
      .ack_i      (cpu_ack_i),
      .tone_idx_o (tone_idx),
      .aux_idx_o  (aux_idx),
      .half_o     (half),
      .irq_o      (irq_o),
      .underrun_o (underrun_o)
   );

   tpb_addr_gen #(
      .ADDR_W       (ADDR_W),
      .NUM_TONES    (NUM_TONES),
      .TONE_SAMPLES (TONE_SAMPLES),
      .AUX_SAMPLES  (AUX_SAMPLES)
   ) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (f_busy),
      .src_aux_i  (f_src),
      .sel_i      (f_sel),
      .chan_i     (f_chan),
      .word_i     (f_word),
      .half_i     (half),
      .tone_idx_i (tone_idx),
      .aux_idx_i  (aux_idx),
      .rd_addr_o  (rd_addr)
   );

   tpb_wr_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_busy_i (f_busy),
      .req_i        (cpu_wr_i),
      .addr_i       (cpu_addr_i),
      .data_i       (cpu_wdata_i),
      .grant_o      (wr_grant),
      .pend_o       (wr_pend),
      .addr_o       (wr_addr),
      .data_o       (wr_data)
   );

   assign mem_rd_o    = f_busy;
   assign mem_wr_o    = wr_grant;
   assign mem_addr_o  = f_busy ? rd_addr : wr_addr;
   assign mem_wdata_o = wr_data;
   assign cpu_busy_o  = wr_pend;
   assign aux_half_o  = half;

   AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o)); // R9

   AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && !f_word) |-> !mem_addr_o[0]); // R2

   AST_PAIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && !f_word) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R2

   AST_TICK_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !mem_rd_o) |=> mem_rd_o); // R2
endmodule

// File: tb/tpb_addr_ctrl_test.sv
module tpb_addr_ctrl_test;
   localparam int ADDR_W = 18;
   localparam int DATA_W = 16;
   localparam int NT     = 4;
   localparam int TS     = 4;
   localparam int AS     = 3;
   localparam int AUXB   = NT * 2 * TS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_i = 1'b0, src_aux_i = 1'b0, cpu_wr_i = 1'b0, cpu_ack_i = 1'b0;
   logic [1:0]        tone_sel_i = '0;
   logic [ADDR_W-1:0] cpu_addr_i = '0;
   logic [DATA_W-1:0] cpu_wdata_i = '0;
   logic [ADDR_W-1:0] mem_addr_o;
   logic              mem_rd_o, mem_wr_o, cpu_busy_o, irq_o, underrun_o, aux_half_o;
   logic [DATA_W-1:0] mem_wdata_o;

   always #2 clk = ~clk;

   tpb_addr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TONES(NT),
                   .TONE_SAMPLES(TS), .AUX_SAMPLES(AS)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .src_aux_i(src_aux_i),
      .tone_sel_i(tone_sel_i), .cpu_wr_i(cpu_wr_i), .cpu_addr_i(cpu_addr_i),
      .cpu_wdata_i(cpu_wdata_i), .cpu_ack_i(cpu_ack_i), .mem_addr_o(mem_addr_o),
      .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
      .cpu_busy_o(cpu_busy_o), .irq_o(irq_o), .underrun_o(underrun_o),
      .aux_half_o(aux_half_o));

   int checks = 0, failures = 0;
   bit finished = 0;
   int exp_rd[$];
   logic [33:0] exp_wr[$];
   string rd_tag[$];

   // bench-side reference state
   int m_chan = 0, m_tidx = 0, m_aidx = 0, m_half = 0, m_irq = 0, m_und = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: issue a tick and push the two expected word addresses
   task automatic do_tick(input bit aux, input int sel, input bit flip_after, input string req);
      int base;
      if (aux) base = AUXB + (2 * m_half + m_chan) * 2 * AS + 2 * m_aidx;
      else     base = sel * 2 * TS + 2 * m_tidx;
      exp_rd.push_back(base);     rd_tag.push_back(req);
      exp_rd.push_back(base + 1); rd_tag.push_back(req);
      @(negedge clk);
      tick_i = 1'b1; src_aux_i = aux; tone_sel_i = 2'(sel);
      @(negedge clk);
      tick_i = 1'b0;
      if (flip_after) begin
         src_aux_i = ~aux; tone_sel_i = 2'(sel + 1);
      end
      if (m_chan == 1) begin
         if (aux) begin
            if (m_aidx == AS - 1) begin
               m_aidx = 0;
               if (m_irq == 1) m_und = 1;
               m_irq = 1;
               m_half = 1 - m_half;
            end else m_aidx++;
         end else m_tidx = (m_tidx + 1) % TS;
      end
      m_chan = 1 - m_chan;
      cycles(3);
   endtask

   task automatic check_flags(input string req);
      chk({req, " irq"}, int'(irq_o), m_irq);
      chk({req, " underrun"}, int'(underrun_o), m_und);
      chk({req, " half"}, int'(aux_half_o), m_half);
   endtask

   task automatic do_ack();
      @(negedge clk); cpu_ack_i = 1'b1;
      @(negedge clk); cpu_ack_i = 1'b0;
      m_irq = 0; m_und = 0;
   endtask

   // monitor: pop expected items as the memory strobes appear
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_rd_o && mem_wr_o) begin
            checks++; failures++;
            $display("FAIL R9 actual=rd+wr expected=one strobe");
         end
         if (mem_rd_o) begin
            if (exp_rd.size() == 0) begin
               checks++; failures++;
               $display("FAIL R2 actual=read@%0d expected=no read", mem_addr_o);
            end else begin
               automatic int e = exp_rd.pop_front();
               automatic string t = rd_tag.pop_front();
               chk({t, " read address"}, int'(mem_addr_o), e);
            end
         end
         if (mem_wr_o) begin
            if (exp_wr.size() == 0) begin
               checks++; failures++;
               $display("FAIL R8 actual=write@%0d expected=no write", mem_addr_o);
            end else begin
               automatic logic [33:0] w = exp_wr.pop_front();
               chk("R8 write address", int'(mem_addr_o), int'(w[33:16]));
               chk("R8 write data", int'(mem_wdata_o), int'(w[15:0]));
            end
         end
      end
   end

   initial begin
      repeat (1000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cycles(3);
      chk("R1 rd", int'(mem_rd_o), 0);
      chk("R1 wr", int'(mem_wr_o), 0);
      chk("R1 busy", int'(cpu_busy_o), 0);
      check_flags("R1");
      rst_n = 1'b1;
      cycles(2);
      chk("R1 rd after release", int'(mem_rd_o), 0);

      // R3: tone table 2 over more than one wrap, then table 1
      for (int i = 0; i < 10; i++) do_tick(1'b0, 2, 1'b0, "R3");
      for (int i = 0; i < 2; i++)  do_tick(1'b0, 1, 1'b0, "R3");

      // R4/R5: play half A through, swap
      for (int i = 0; i < 2 * AS; i++) do_tick(1'b1, 0, 1'b0, "R4");
      check_flags("R5");
      do_ack();
      check_flags("R6");

      // R7: two swaps without acknowledge
      for (int i = 0; i < 2 * AS; i++) do_tick(1'b1, 0, 1'b0, "R5");
      check_flags("R5 second swap");
      for (int i = 0; i < 2 * AS; i++) do_tick(1'b1, 0, 1'b0, "R7");
      check_flags("R7");
      do_ack();
      check_flags("R6 clear underrun");

      // R10: inputs change during a fetch; tone pointer kept across aux use
      do_tick(1'b1, 0, 1'b1, "R10");
      do_tick(1'b0, 3, 1'b1, "R10");
      do_tick(1'b1, 0, 1'b0, "R10");
      do_tick(1'b0, 0, 1'b0, "R10");

      // R8: write into an idle slot
      exp_wr.push_back({18'd1234, 16'hBEEF});
      @(negedge clk);
      cpu_wr_i = 1'b1; cpu_addr_i = 18'd1234; cpu_wdata_i = 16'hBEEF;
      @(negedge clk);
      cpu_wr_i = 1'b0;
      chk("R8 busy idle write", int'(cpu_busy_o), 1);
      chk("R8 strobe idle write", int'(mem_wr_o), 1);
      @(negedge clk);
      chk("R8 busy released", int'(cpu_busy_o), 0);

      // R8: write issued with a tick is held behind the fetch
      exp_wr.push_back({18'd77, 16'h0A5A});
      exp_rd.push_back(AUXB + (2 * m_half + m_chan) * 2 * AS + 2 * m_aidx);
      rd_tag.push_back("R8");
      exp_rd.push_back(AUXB + (2 * m_half + m_chan) * 2 * AS + 2 * m_aidx + 1);
      rd_tag.push_back("R8");
      @(negedge clk);
      tick_i = 1'b1; src_aux_i = 1'b1;
      cpu_wr_i = 1'b1; cpu_addr_i = 18'd77; cpu_wdata_i = 16'h0A5A;
      @(negedge clk);
      tick_i = 1'b0; cpu_wr_i = 1'b0;
      chk("R8 held during word0", int'(mem_wr_o), 0);
      chk("R8 busy during fetch", int'(cpu_busy_o), 1);
      @(negedge clk);
      chk("R8 held during word1", int'(mem_wr_o), 0);
      @(negedge clk);
      chk("R8 write after fetch", int'(mem_wr_o), 1);
      @(negedge clk);
      chk("R8 busy after write", int'(cpu_busy_o), 0);
      if (m_chan == 1) m_aidx = (m_aidx + 1) % AS;
      m_chan = 1 - m_chan;
      cycles(3);

      chk("R2 all reads seen", exp_rd.size(), 0);
      chk("R8 all writes seen", exp_wr.size(), 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule